// File: doc/BRIEF.md
# Debug Port Request Control and Status Register

This block is a 32-bit control/status word placed between host software and a USB debug-port transaction engine. Software uses host-bus writes to enable the port, mark it as claimed, choose the transfer direction and start a request. The block turns an accepted start into a one-cycle launch pulse to the engine. It then waits for the engine's one-cycle completion pulse and records whether the request succeeded, failed, or hit a coded exception. Software reads the result back from the same word.

The block also watches the state of the associated root port. The enable bit can be set only while that port is already enabled, and any enable-change event on the port clears it. A start issued while the port is suspended or held in reset never reaches the engine. Such a request completes locally one cycle later and reports a hardware exception.

Top module: `dbgp_ctrl_reg`

## Requirements
- R1: Bit 28 (enable) is set by a write with bit 28 = 1 only when `port_enabled` is 1 in that cycle; a write with bit 28 = 0 clears it; a write of 1 while the port is disabled leaves it 0.
- R2: Enable resets to 0, and `port_en_change` = 1 clears it at the next edge, taking priority over a same-cycle write of 1.
- R3: Bit 16 (done) is set when a request completes. Writing 1 to bit 16 clears it, and writing 0 leaves it unchanged. If a completion and a clear occur in the same cycle, done ends up set.
- R4: Bits 15:12 (link identity) always read 0h, and bits 29, 27:17 and 11 always read 0. Writes to any of these bits have no visible effect.
- R5: Bit 10 (claimed) is plain read/write with reset value 0, and it changes no other output.
- R6: Writing 1 to bit 5 while idle and unblocked makes `eng_start` high for exactly one cycle, on the cycle after the write. `eng_write` carries the bit 4 value of that write (0 = read, 1 = write) and holds it until the request completes, even if bit 4 is rewritten.
- R7: Bit 5 reads 1 from the edge after an accepted start until the edge at which done is set, where it returns to 0. A write of 1 to bit 5 while a request is pending is ignored and produces no second `eng_start`.
- R8: On an engine completion, bit 6 (error) takes `eng_err`. Bits 9:7 take 000 when `eng_err` = 0 and {0, `eng_err_kind`} otherwise: 001 means a transaction error and 010 means a hardware error. Bits 6 and 9:7 change at no other time except under R9.
- R9: A start written while `port_suspended` or `port_in_reset` is 1 produces no `eng_start`. At the second edge after the write, the request completes with done = 1, error = 1 and exception = 010.
- R10: `eng_done` is ignored unless a launched request is waiting for its completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Host write strobe, one word per cycle |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Current register contents |
| port_enabled | input | 1 | Associated root port is enabled |
| port_en_change | input | 1 | Root port enable/disable change event |
| port_suspended | input | 1 | Root port is suspended |
| port_in_reset | input | 1 | Root port is in reset |
| eng_start | output | 1 | One-cycle request launch to the engine |
| eng_write | output | 1 | Request direction, 1 = write |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_err | input | 1 | Completion ended in error |
| eng_err_kind | input | 2 | Error kind: 01 transaction, 10 hardware |

## Verification
The assertions assume two things about the engine. It raises `eng_done` for one cycle per launch, and only after the launch pulse. `eng_err_kind` is meaningful only when `eng_err` is set. The stimulus follows both rules for every request it starts: it holds completion off for at least one cycle after `eng_start` and always pairs an error with kind 01. It also injects one stray completion while the block is idle, which the block must ignore. The host bus carries no back-pressure, so every write lands in the cycle it is presented, and the stimulus issues at most one write per cycle.

// File: rtl/dbgp_pkg.sv
`timescale 1ns/1ps
package dbgp_pkg;
  localparam int REG_W     = 32;
  localparam int EN_BIT    = 28;
  localparam int DONE_BIT  = 16;
  localparam int LINK_LSB  = 12;
  localparam int LINK_W    = 4;
  localparam int CLAIM_BIT = 10;
  localparam int EXC_LSB   = 7;
  localparam int EXC_W     = 3;
  localparam int ERR_BIT   = 6;
  localparam int GO_BIT    = 5;
  localparam int DIR_BIT   = 4;
  localparam int KIND_W    = 2;

  localparam logic [EXC_W-1:0]  EXC_NONE = 3'b000;
  localparam logic [EXC_W-1:0]  EXC_HW   = 3'b010;
  localparam logic [LINK_W-1:0] LINK_DBG = 4'h0;

  typedef enum logic [1:0] {
    REQ_IDLE  = 2'd0,
    REQ_ISSUE = 2'd1,
    REQ_WAIT  = 2'd2,
    REQ_FAIL  = 2'd3
  } req_state_e;
endpackage

// File: rtl/dbgp_enable_ctl.sv
`timescale 1ns/1ps
module dbgp_enable_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  input  logic port_enabled,
  input  logic port_en_change,
  output logic en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (port_en_change) begin
      en_q <= 1'b0;
    end else if (wr_en) begin
      if (!wr_val)
        en_q <= 1'b0;
      else if (port_enabled)
        en_q <= 1'b1;
    end
  end
endmodule

// File: rtl/dbgp_req_fsm.sv
`timescale 1ns/1ps
module dbgp_req_fsm
  import dbgp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go_wr,
  input  logic dir_in,
  input  logic blocked,
  input  logic eng_done,
  output logic eng_start,
  output logic eng_write,
  output logic busy,
  output logic cpl_ok,
  output logic cpl_fail
);
  req_state_e state_q, state_d;
  logic       dir_q;
  logic       accept;

  assign accept = go_wr && (state_q == REQ_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      REQ_IDLE:  if (go_wr) state_d = blocked ? REQ_FAIL : REQ_ISSUE;
      REQ_ISSUE: state_d = REQ_WAIT;
      REQ_WAIT:  if (eng_done) state_d = REQ_IDLE;
      REQ_FAIL:  state_d = REQ_IDLE;
      default:   state_d = REQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= REQ_IDLE;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) dir_q <= dir_in;
    end
  end

  assign eng_start = (state_q == REQ_ISSUE);
  assign eng_write = dir_q;
  assign busy      = (state_q != REQ_IDLE);
  assign cpl_ok    = (state_q == REQ_WAIT) && eng_done;
  assign cpl_fail  = (state_q == REQ_FAIL);
endmodule

// File: rtl/dbgp_status_cap.sv
`timescale 1ns/1ps
module dbgp_status_cap
  import dbgp_pkg::*;
#(
  parameter int KW = KIND_W,
  parameter int XW = EXC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpl_ok,
  input  logic          cpl_fail,
  input  logic          eng_err,
  input  logic [KW-1:0] eng_err_kind,
  input  logic          done_clr,
  output logic          done_q,
  output logic          err_q,
  output logic [XW-1:0] exc_q
);
  localparam int PAD_W = XW - KW;

  logic [XW-1:0] kind_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign kind_ext = {{PAD_W{1'b0}}, eng_err_kind};
    end else begin : g_nopad
      assign kind_ext = eng_err_kind[XW-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      exc_q  <= EXC_NONE;
    end else begin
      if (cpl_ok || cpl_fail)
        done_q <= 1'b1;
      else if (done_clr)
        done_q <= 1'b0;

      if (cpl_fail) begin
        err_q <= 1'b1;
        exc_q <= EXC_HW;
      end else if (cpl_ok) begin
        err_q <= eng_err;
        exc_q <= eng_err ? kind_ext : EXC_NONE;
      end
    end
  end
endmodule

// File: rtl/dbgp_ctrl_reg.sv
`timescale 1ns/1ps
module dbgp_ctrl_reg
  import dbgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              port_enabled,
  input  logic              port_en_change,
  input  logic              port_suspended,
  input  logic              port_in_reset,
  output logic              eng_start,
  output logic              eng_write,
  input  logic              eng_done,
  input  logic              eng_err,
  input  logic [KIND_W-1:0] eng_err_kind
);
  logic             en_q, claim_q, dir_q;
  logic             busy, cpl_ok, cpl_fail;
  logic             done_q, err_q;
  logic [EXC_W-1:0] exc_q;
  logic             unused_wbits;

  assign unused_wbits = ^{reg_wdata[31:29], reg_wdata[27:17],
                          reg_wdata[15:11], reg_wdata[9:6], reg_wdata[3:0]};

  dbgp_enable_ctl u_en (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_en          (reg_we),
    .wr_val         (reg_wdata[EN_BIT]),
    .port_enabled   (port_enabled),
    .port_en_change (port_en_change),
    .en_q           (en_q)
  );

  dbgp_req_fsm u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .go_wr     (reg_we && reg_wdata[GO_BIT]),
    .dir_in    (reg_wdata[DIR_BIT]),
    .blocked   (port_suspended || port_in_reset),
    .eng_done  (eng_done),
    .eng_start (eng_start),
    .eng_write (eng_write),
    .busy      (busy),
    .cpl_ok    (cpl_ok),
    .cpl_fail  (cpl_fail)
  );

  dbgp_status_cap #(.KW(KIND_W), .XW(EXC_W)) u_sts (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpl_ok       (cpl_ok),
    .cpl_fail     (cpl_fail),
    .eng_err      (eng_err),
    .eng_err_kind (eng_err_kind),
    .done_clr     (reg_we && reg_wdata[DONE_BIT]),
    .done_q       (done_q),
    .err_q        (err_q),
    .exc_q        (exc_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      claim_q <= 1'b0;
      dir_q   <= 1'b0;
    end else if (reg_we) begin
      claim_q <= reg_wdata[CLAIM_BIT];
      dir_q   <= reg_wdata[DIR_BIT];
    end
  end

  always_comb begin
    reg_rdata                           = '0;
    reg_rdata[EN_BIT]                   = en_q;
    reg_rdata[DONE_BIT]                 = done_q;
    reg_rdata[LINK_LSB +: LINK_W]       = LINK_DBG;
    reg_rdata[CLAIM_BIT]                = claim_q;
    reg_rdata[EXC_LSB +: EXC_W]         = exc_q;
    reg_rdata[ERR_BIT]                  = err_q;
    reg_rdata[GO_BIT]                   = busy;
    reg_rdata[DIR_BIT]                  = dir_q;
  end
endmodule

// File: rtl/dbgp_ctrl_reg_chk.sv
`timescale 1ns/1ps
module dbgp_ctrl_reg_chk
  import dbgp_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [REG_W-1:0] reg_wdata,
  input logic [REG_W-1:0] reg_rdata,
  input logic             port_enabled,
  input logic             port_en_change,
  input logic             port_suspended,
  input logic             port_in_reset,
  input logic             eng_start,
  input logic             eng_write
);
  AST_EN_SET_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[EN_BIT]) |-> $past(reg_we && reg_wdata[EN_BIT] && port_enabled)); // R1

  AST_EN_CHANGE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    port_en_change |=> !reg_rdata[EN_BIT]); // R2

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[DONE_BIT] && !(reg_we && reg_wdata[DONE_BIT])) |=> reg_rdata[DONE_BIT]); // R3

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start); // R6

  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[GO_BIT] && $past(reg_rdata[GO_BIT])) |-> $stable(eng_write)); // R6

  AST_GO_FALLS_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reg_rdata[GO_BIT]) |-> reg_rdata[DONE_BIT]); // R7

  AST_ERR_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_rdata[ERR_BIT]) |-> $fell(reg_rdata[GO_BIT])); // R8

  AST_NO_START_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> $past(!(port_suspended || port_in_reset))); // R9
endmodule

bind dbgp_ctrl_reg dbgp_ctrl_reg_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_we         (reg_we),
  .reg_wdata      (reg_wdata),
  .reg_rdata      (reg_rdata),
  .port_enabled   (port_enabled),
  .port_en_change (port_en_change),
  .port_suspended (port_suspended),
  .port_in_reset  (port_in_reset),
  .eng_start      (eng_start),
  .eng_write      (eng_write)
);

// File: tb/test_dbgp_ctrl_reg.sv
`timescale 1ns/1ps
module test_dbgp_ctrl_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        port_enabled = 1'b0, port_en_change = 1'b0;
  logic        port_suspended = 1'b0, port_in_reset = 1'b0;
  logic        eng_start, eng_write;
  logic        eng_done = 1'b0, eng_err = 1'b0;
  logic [1:0]  eng_err_kind = 2'b00;

  int nvec = 0;
  int nbad = 0;
  bit finished = 1'b0;

  logic [33:0] exp_q[$];
  string       tag_q[$];

  localparam logic [31:0] EN = 32'h1000_0000, DN = 32'h0001_0000, IU = 32'h0000_0400;
  localparam logic [31:0] GO = 32'h0000_0020, DR = 32'h0000_0010;

  always #4 clk = ~clk;

  dbgp_ctrl_reg i_dbgp_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .port_enabled(port_enabled),
    .port_en_change(port_en_change), .port_suspended(port_suspended),
    .port_in_reset(port_in_reset), .eng_start(eng_start), .eng_write(eng_write),
    .eng_done(eng_done), .eng_err(eng_err), .eng_err_kind(eng_err_kind)
  );

  // monitor: one expected item per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [33:0] e;
      logic [33:0] a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {eng_start, eng_write, reg_rdata};
      nvec++;
      if (a !== e) begin
        nbad++;
        $display("FAIL %s: got start=%b wr=%b rdata=%h, expected start=%b wr=%b rdata=%h",
                 t, a[33], a[32], a[31:0], e[33], e[32], e[31:0]);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  // driver: advance one cycle, queue what the outputs must show now
  task automatic step(input logic st, input logic wr, input logic [31:0] rd, input string t);
    tick();
    exp_q.push_back({st, wr, rd});
    tag_q.push_back(t);
  endtask

  task automatic wr(input logic [31:0] d);
    reg_we = 1'b1;
    reg_wdata = d;
  endtask

  task automatic nowr();
    reg_we = 1'b0;
    reg_wdata = '0;
  endtask

  initial begin
    tick(); tick(); tick();
    rst_n = 1'b1;
    step(0, 0, 32'h0, "R2 R4 R5 reset");
    wr(32'hFFFE_FFDF);                       // port disabled
    step(0, 0, IU | DR, "R1 R4 R5 set refused, reserved ignored");
    port_enabled = 1'b1; wr(EN | IU | DR);
    step(0, 0, EN | IU | DR, "R1 set with port enabled");
    wr(IU | DR);
    step(0, 0, IU | DR, "R1 write 0 clears");
    port_en_change = 1'b1; wr(EN | IU | DR);
    step(0, 0, IU | DR, "R2 change beats write");
    port_en_change = 1'b0;
    step(0, 0, EN | IU | DR, "R1 set again");
    nowr(); port_en_change = 1'b1;
    step(0, 0, IU | DR, "R2 change clears");
    port_en_change = 1'b0; wr(EN | IU | GO | DR);
    step(1, 1, EN | IU | GO | DR, "R6 start pulse write dir");
    wr(EN | IU | GO);                        // retrigger while pending
    step(0, 1, EN | IU | GO, "R7 R6 pending, dir held");
    nowr();
    step(0, 1, EN | IU | GO, "R7 no second start");
    eng_done = 1'b1; eng_err = 1'b0;
    step(0, 1, EN | IU | DN, "R3 R7 R8 good completion");
    eng_done = 1'b0; wr(EN | IU);
    step(0, 1, EN | IU | DN, "R3 write 0 keeps done");
    wr(EN | IU | DN);
    step(0, 1, EN | IU, "R3 write 1 clears done");
    nowr(); eng_done = 1'b1; eng_err = 1'b1; eng_err_kind = 2'b01;
    step(0, 1, EN | IU, "R10 stray completion ignored");
    eng_done = 1'b0; eng_err = 1'b0; eng_err_kind = 2'b00; wr(EN | IU | GO);
    step(1, 0, EN | IU | GO, "R6 start pulse read dir");
    nowr();
    step(0, 0, EN | IU | GO, "R7 waiting");
    eng_done = 1'b1; eng_err = 1'b1; eng_err_kind = 2'b01; wr(EN | IU | DN);
    step(0, 0, EN | IU | DN | 32'h80 | 32'h40, "R3 R8 error completion, set beats clear");
    eng_done = 1'b0; eng_err = 1'b0; eng_err_kind = 2'b00;
    port_suspended = 1'b1; wr(EN | IU | GO | DN);
    step(0, 0, EN | IU | GO | 32'h80 | 32'h40, "R9 R8 suspended start, no pulse");
    port_suspended = 1'b0; nowr();
    step(0, 0, EN | IU | DN | 32'h100 | 32'h40, "R9 hw error completion");
    port_in_reset = 1'b1; wr(EN | IU | GO | DR | DN);
    step(0, 1, EN | IU | GO | DR | 32'h140, "R9 in-reset start, no pulse");
    port_in_reset = 1'b0; nowr();
    step(0, 1, EN | IU | DN | DR | 32'h140, "R9 hw error completion 2");
    wr(EN | IU | GO | DN);
    step(1, 0, EN | IU | GO | 32'h140, "R6 R8 restart keeps old error");
    nowr();
    step(0, 0, EN | IU | GO | 32'h140, "R7 waiting 2");
    eng_done = 1'b1;
    step(0, 0, EN | IU | DN, "R8 success clears error");
    eng_done = 1'b0;
    tick(); tick();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      nbad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule